// File: doc/BRIEF.md
# Dispatch Group Slot Hazard Checker

This block follows an in-order front end as it packs instructions into a dispatch group of five slots. Each cycle, the front end shows it one candidate instruction. The candidate comes with a unit class code and a few attribute bits: first-only, single, cracked, writes-count-register and branches-through-count-register. The block answers at once with one of three verdicts. The candidate may join the current group, it must wait for a fresh group, or a no-op must be inserted ahead of it.

When the front end actually dispatches, it raises the issue strobe. When a cycle passes with nothing dispatched, it raises the advance strobe. In both cases the block moves its slot count forward on the next clock edge.

The group state is a five-state machine, one state per number of used slots:

| State | Slots used |
|---|---|
| `GRP_EMPTY` | 0 |
| `GRP_ONE` | 1 |
| `GRP_TWO` | 2 |
| `GRP_THREE` | 3 |
| `GRP_FOUR` | 4 |

The named transitions are:

- `HOLD`: nothing counted, so the state stays.
- `STEP_ONE`: one slot is taken, by a plain issue or by an advance.
- `STEP_TWO`: a cracked issue takes two slots.
- `CLOSE`: the count reaches five, or a branch or single instruction is issued. The machine returns to `GRP_EMPTY` and clears the count-register hazard flag.

Top module: `dgroup_hazard_chk`

## Requirements
- R1: After a synchronous active-high reset, the group is empty: `slot_cnt_o` is 0, the hazard flag is clear, and a valid fixed-point candidate gets verdict `2'b00` (ok). The other verdict codes are `2'b01` (stall) and `2'b10` (noop-needed). The class codes are: 0 pseudo, 1 fixed-point, 2 load/store, 3 floating-point, 4 vector ALU, 5 vector permute, 6 condition-register, 7 branch.
- R2: A valid candidate marked first-only or single gets stall whenever `slot_cnt_o` is not 0. At count 0 it may be ok.
- R3: A valid cracked candidate gets stall when `slot_cnt_o` is greater than 2. At count 2 it may be ok.
- R4: A valid candidate of classes 1 to 5 gets stall at count 4. A branch (class 7) at count 4 may be ok.
- R5: A valid condition-register candidate (class 6) gets stall at count 2 or more.
- R6: An earlier issue in the same group had writes-count-register set. A later valid candidate with branches-through-count-register set then gets noop-needed. If a stall condition holds in the same cycle, stall wins.
- R7: Each issue adds one slot and a cracked issue adds two. When the count reaches five or more, the group goes back to empty and the count-register hazard is cleared.
- R8: Issuing a branch or a single instruction closes the group, so the count is 0 after the next edge.
- R9: An advance strobe adds one slot. When issue is raised in the same cycle, the advance is ignored.
- R10: A pseudo candidate (class 0) always gets ok, whatever its attributes. Issuing it leaves the count and the hazard unchanged.
- R11: The verdict depends only on the current inputs and state, within the same cycle. The count changes on the first clock edge after a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| cand_vld_i | input | 1 | A candidate is presented |
| cand_cls_i | input | 3 | Unit class code of the candidate |
| cand_first_i | input | 1 | Candidate may only start a group |
| cand_single_i | input | 1 | Candidate fills a group alone |
| cand_crack_i | input | 1 | Candidate takes two slots |
| cand_setctr_i | input | 1 | Candidate writes the count register |
| cand_brctr_i | input | 1 | Candidate branches through the count register |
| issue_i | input | 1 | The candidate is dispatched this cycle |
| advance_i | input | 1 | An empty dispatch cycle passes |
| verdict_o | output | 2 | 00 ok, 01 stall, 10 noop-needed |
| slot_cnt_o | output | 3 | Slots used in the current group |

## Verification
The verdict is combinational, so it is due in the same cycle the candidate is driven. The bench samples it 2 ns after driving the inputs on the falling edge, before the next rising edge. The slot count and the count-register hazard pass through one register, so they are due one rising edge after the strobe. The bench reads them at the following falling edge. Every vector in the table therefore checks the verdict first, then the count after exactly one edge, and never reads either value across more than one edge.

// File: rtl/dgroup_pkg.sv
package dgroup_pkg;

    localparam int GRP_SLOTS = 5;
    localparam int CNT_W     = $clog2(GRP_SLOTS + 1);

    typedef enum logic [2:0] {
        CLS_PSEUDO = 3'd0,
        CLS_FIX    = 3'd1,
        CLS_LSU    = 3'd2,
        CLS_FPU    = 3'd3,
        CLS_VALU   = 3'd4,
        CLS_VPERM  = 3'd5,
        CLS_CR     = 3'd6,
        CLS_BR     = 3'd7
    } unit_cls_e;

    typedef enum logic [1:0] {
        VERD_OK    = 2'b00,
        VERD_STALL = 2'b01,
        VERD_NOOP  = 2'b10
    } verdict_e;

    typedef enum logic [2:0] {
        GRP_EMPTY = 3'd0,
        GRP_ONE   = 3'd1,
        GRP_TWO   = 3'd2,
        GRP_THREE = 3'd3,
        GRP_FOUR  = 3'd4
    } grp_state_e;

    typedef enum logic [1:0] {
        TR_HOLD,
        TR_STEP_ONE,
        TR_STEP_TWO,
        TR_CLOSE
    } grp_trans_e;

endpackage

// File: rtl/dgroup_rules.sv
module dgroup_rules
    import dgroup_pkg::*;
#(
    parameter int CNT_W_P     = 3,
    parameter int CR_LIMIT    = 2,
    parameter int CRACK_LIMIT = 2,
    parameter int LAST_NB     = 4
) (
    input  logic [CNT_W_P-1:0] cnt_i,
    input  logic               vld_i,
    input  logic [2:0]         cls_i,
    input  logic               first_i,
    input  logic               single_i,
    input  logic               crack_i,
    input  logic               brctr_i,
    input  logic               ctr_armed_i,
    output logic [1:0]         verdict_o
);

    localparam logic [CNT_W_P-1:0] CR_LIM_V    = CR_LIMIT[CNT_W_P-1:0];
    localparam logic [CNT_W_P-1:0] CRACK_LIM_V = CRACK_LIMIT[CNT_W_P-1:0];
    localparam logic [CNT_W_P-1:0] LAST_V      = LAST_NB[CNT_W_P-1:0];

    logic pos_stall;
    logic cls_stall;
    logic noop_need;
    logic real_cand;

    assign real_cand = vld_i && (cls_i != CLS_PSEUDO);

    // Position limits that hold for every class.
    always_comb begin
        pos_stall = 1'b0;
        if ((first_i || single_i) && (cnt_i != '0)) begin
            pos_stall = 1'b1;
        end
        if (crack_i && (cnt_i > CRACK_LIM_V)) begin
            pos_stall = 1'b1;
        end
    end

    // Limits that depend on the unit class.
    always_comb begin
        cls_stall = 1'b0;
        unique case (unit_cls_e'(cls_i))
            CLS_FIX, CLS_LSU, CLS_FPU, CLS_VALU, CLS_VPERM:
                cls_stall = (cnt_i == LAST_V);
            CLS_CR:
                cls_stall = (cnt_i >= CR_LIM_V);
            CLS_BR, CLS_PSEUDO:
                cls_stall = 1'b0;
            default:
                cls_stall = 1'b0;
        endcase
    end

    assign noop_need = ctr_armed_i && brctr_i;

    // Stall outranks a no-op.
    always_comb begin
        verdict_o = VERD_OK;
        if (real_cand) begin
            if (pos_stall || cls_stall) begin
                verdict_o = VERD_STALL;
            end else if (noop_need) begin
                verdict_o = VERD_NOOP;
            end
        end
    end

endmodule

// File: rtl/dgroup_fsm.sv
module dgroup_fsm
    import dgroup_pkg::*;
#(
    parameter int SLOTS   = 5,
    parameter int CNT_W_P = 3
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               issue_en_i,
    input  logic               close_i,
    input  logic               crack_i,
    input  logic               setctr_i,
    input  logic               adv_en_i,
    output logic [CNT_W_P-1:0] cnt_o,
    output logic               ctr_armed_o
);

    localparam int SUM_W = CNT_W_P + 1;
    localparam logic [SUM_W-1:0] FULL_V  = SLOTS[SUM_W-1:0];
    localparam logic [SUM_W-1:0] CLOSE_V = SUM_W'(SLOTS - 1);

    grp_state_e       state_q, state_d;
    grp_trans_e       trans;
    logic             armed_q, armed_d;
    logic [SUM_W-1:0] cur_cnt;
    logic [SUM_W-1:0] base;
    logic [SUM_W-1:0] sum;

    // Slot count carried by each state.
    always_comb begin
        unique case (state_q)
            GRP_EMPTY: cur_cnt = SUM_W'(0);
            GRP_ONE:   cur_cnt = SUM_W'(1);
            GRP_TWO:   cur_cnt = SUM_W'(2);
            GRP_THREE: cur_cnt = SUM_W'(3);
            GRP_FOUR:  cur_cnt = SUM_W'(4);
            default:   cur_cnt = SUM_W'(0);
        endcase
    end

    // Pick the transition and compute the new count.
    always_comb begin
        base = close_i ? CLOSE_V : cur_cnt;
        sum  = cur_cnt;
        if (issue_en_i) begin
            sum = base + SUM_W'(1) + SUM_W'(crack_i);
        end else if (adv_en_i) begin
            sum = cur_cnt + SUM_W'(1);
        end

        if (sum >= FULL_V) begin
            trans = TR_CLOSE;
        end else if (sum == cur_cnt) begin
            trans = TR_HOLD;
        end else if (sum == cur_cnt + SUM_W'(2)) begin
            trans = TR_STEP_TWO;
        end else begin
            trans = TR_STEP_ONE;
        end
    end

    // Next state and hazard flag.
    always_comb begin
        state_d = state_q;
        armed_d = armed_q || (issue_en_i && setctr_i);
        unique case (trans)
            TR_HOLD: begin
                state_d = state_q;
            end
            TR_STEP_ONE, TR_STEP_TWO: begin
                unique case (sum[CNT_W_P-1:0])
                    CNT_W_P'(1): state_d = GRP_ONE;
                    CNT_W_P'(2): state_d = GRP_TWO;
                    CNT_W_P'(3): state_d = GRP_THREE;
                    CNT_W_P'(4): state_d = GRP_FOUR;
                    default:     state_d = GRP_EMPTY;
                endcase
            end
            TR_CLOSE: begin
                state_d = GRP_EMPTY;
                armed_d = 1'b0;
            end
            default: begin
                state_d = GRP_EMPTY;
                armed_d = 1'b0;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= GRP_EMPTY;
            armed_q <= 1'b0;
        end else begin
            state_q <= state_d;
            armed_q <= armed_d;
        end
    end

    // Outputs.
    always_comb begin
        cnt_o       = cur_cnt[CNT_W_P-1:0];
        ctr_armed_o = armed_q;
    end

endmodule

// File: rtl/dgroup_hazard_chk.sv
module dgroup_hazard_chk
    import dgroup_pkg::*;
#(
    parameter int SLOTS       = GRP_SLOTS,
    parameter int CR_LIMIT    = 2,
    parameter int CRACK_LIMIT = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             cand_vld_i,
    input  logic [2:0]       cand_cls_i,
    input  logic             cand_first_i,
    input  logic             cand_single_i,
    input  logic             cand_crack_i,
    input  logic             cand_setctr_i,
    input  logic             cand_brctr_i,
    input  logic             issue_i,
    input  logic             advance_i,
    output logic [1:0]       verdict_o,
    output logic [CNT_W-1:0] slot_cnt_o
);

    localparam int LAST_NB = SLOTS - 1;

    logic             real_issue;
    logic             close_req;
    logic             adv_only;
    logic             ctr_armed;
    logic [CNT_W-1:0] cnt;

    assign real_issue = issue_i && cand_vld_i && (cand_cls_i != CLS_PSEUDO);
    assign close_req  = (cand_cls_i == CLS_BR) || cand_single_i;
    assign adv_only   = advance_i && !issue_i;

    dgroup_rules #(
        .CNT_W_P     (CNT_W),
        .CR_LIMIT    (CR_LIMIT),
        .CRACK_LIMIT (CRACK_LIMIT),
        .LAST_NB     (LAST_NB)
    ) u_rules (
        .cnt_i       (cnt),
        .vld_i       (cand_vld_i),
        .cls_i       (cand_cls_i),
        .first_i     (cand_first_i),
        .single_i    (cand_single_i),
        .crack_i     (cand_crack_i),
        .brctr_i     (cand_brctr_i),
        .ctr_armed_i (ctr_armed),
        .verdict_o   (verdict_o)
    );

    dgroup_fsm #(
        .SLOTS   (SLOTS),
        .CNT_W_P (CNT_W)
    ) u_fsm (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .issue_en_i  (real_issue),
        .close_i     (close_req),
        .crack_i     (cand_crack_i),
        .setctr_i    (cand_setctr_i),
        .adv_en_i    (adv_only),
        .cnt_o       (cnt),
        .ctr_armed_o (ctr_armed)
    );

    assign slot_cnt_o = cnt;

endmodule

// File: rtl/dgroup_hazard_chk_sva.sv
module dgroup_hazard_chk_sva
    import dgroup_pkg::*;
(
    input logic             clk_i,
    input logic             rst_i,
    input logic             cand_vld_i,
    input logic [2:0]       cand_cls_i,
    input logic             cand_first_i,
    input logic             cand_single_i,
    input logic             issue_i,
    input logic             advance_i,
    input logic [1:0]       verdict_o,
    input logic [CNT_W-1:0] slot_cnt_o
);

    // Advance never meets a full group (R9).
    assert_adv_not_full_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        advance_i |-> (slot_cnt_o < CNT_W'(GRP_SLOTS)));

    // Advance alone moves the count by one, wrapping at the end (R9).
    assert_adv_step_R9: assert property (@(posedge clk_i) disable iff (rst_i)
        (advance_i && !issue_i) |=>
            (slot_cnt_o == (($past(slot_cnt_o) == CNT_W'(GRP_SLOTS - 1)) ? CNT_W'(0)
                                                                        : $past(slot_cnt_o) + CNT_W'(1))));

    // First-only or single at a non-empty group stalls (R2).
    assert_first_stall_R2: assert property (@(posedge clk_i) disable iff (rst_i)
        (cand_vld_i && cand_cls_i != CLS_PSEUDO && (cand_first_i || cand_single_i)
         && slot_cnt_o != '0) |-> (verdict_o == VERD_STALL));

    // Condition-register class from slot two on stalls (R5).
    assert_cr_stall_R5: assert property (@(posedge clk_i) disable iff (rst_i)
        (cand_vld_i && cand_cls_i == CLS_CR && slot_cnt_o >= CNT_W'(2))
            |-> (verdict_o == VERD_STALL));

    // Pseudo issue changes nothing (R10).
    assert_pseudo_hold_R10: assert property (@(posedge clk_i) disable iff (rst_i)
        (issue_i && cand_cls_i == CLS_PSEUDO) |=> $stable(slot_cnt_o));

    // Verdict code 11 never appears (R1).
    assert_verdict_legal_R1: assert property (@(posedge clk_i) disable iff (rst_i)
        verdict_o != 2'b11);

endmodule

bind dgroup_hazard_chk dgroup_hazard_chk_sva u_sva (
    .clk_i         (clk_i),
    .rst_i         (rst_i),
    .cand_vld_i    (cand_vld_i),
    .cand_cls_i    (cand_cls_i),
    .cand_first_i  (cand_first_i),
    .cand_single_i (cand_single_i),
    .issue_i       (issue_i),
    .advance_i     (advance_i),
    .verdict_o     (verdict_o),
    .slot_cnt_o    (slot_cnt_o)
);

// File: tb/dgroup_hazard_chk_bench.sv
module dgroup_hazard_chk_bench;

    // Vector layout: rst vld cls first single crack setctr brctr issue adv | verdict cnt_after | req
    typedef struct packed {
        logic       rst;
        logic       vld;
        logic [2:0] cls;
        logic       fo;
        logic       sg;
        logic       cr;
        logic       sc;
        logic       bc;
        logic       iss;
        logic       adv;
        logic [1:0] ev;
        logic [2:0] ec;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,3'd1,4'd7},  // R7 plain issue
        '{1'b0,1'b1,3'd1,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,3'd1,4'd2},  // R2 first-only late
        '{1'b0,1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd1,4'd5},  // R5 CR at 1 ok
        '{1'b0,1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,3'd2,4'd5},  // R5 issue CR
        '{1'b0,1'b1,3'd6,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,3'd2,4'd5},  // R5 CR at 2 stall
        '{1'b0,1'b1,3'd2,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,3'd4,4'd3},  // R3 cracked at 2 ok
        '{1'b0,1'b1,3'd1,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,2'd1,3'd4,4'd3},  // R3 cracked at 4 stall
        '{1'b0,1'b1,3'd3,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,3'd4,4'd4},  // R4 FPU at 4
        '{1'b0,1'b1,3'd4,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,3'd4,4'd4},  // R4 VALU at 4
        '{1'b0,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd4,4'd4},  // R4 branch at 4 ok
        '{1'b0,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,3'd0,4'd8},  // R8 branch closes
        '{1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,3'd1,4'd6},  // R6 set ctr
        '{1'b0,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd2,3'd1,4'd6},  // R6 noop
        '{1'b0,1'b1,3'd7,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd1,3'd1,4'd6},  // R6 stall wins
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,3'd2,4'd9},  // R9 advance
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,3'd3,4'd9},  // R9 advance
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,3'd4,4'd9},  // R9 advance
        '{1'b0,1'b0,3'd0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'd0,3'd0,4'd7},  // R7 wrap at five
        '{1'b0,1'b1,3'd7,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,3'd0,4'd7},  // R7 hazard cleared
        '{1'b0,1'b1,3'd4,1'b0,1'b1,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,3'd0,4'd8},  // R8 single closes
        '{1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,2'd0,3'd1,4'd7},  // R7 issue
        '{1'b0,1'b1,3'd0,1'b1,1'b1,1'b1,1'b1,1'b0,1'b1,1'b0,2'd0,3'd1,4'd10}, // R10 pseudo
        '{1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,2'd0,3'd2,4'd9},  // R9 adv ignored
        '{1'b1,1'b1,3'd1,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd0,4'd1}   // R1 reset mid-group
    };

    logic       clk = 1'b0;
    logic       rst;
    logic       vld, fo, sg, cr, sc, bc, iss, adv;
    logic [2:0] cls;
    logic [1:0] verdict;
    logic [2:0] cnt;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    dgroup_hazard_chk u_dgroup_hazard_chk (
        .clk_i         (clk),
        .rst_i         (rst),
        .cand_vld_i    (vld),
        .cand_cls_i    (cls),
        .cand_first_i  (fo),
        .cand_single_i (sg),
        .cand_crack_i  (cr),
        .cand_setctr_i (sc),
        .cand_brctr_i  (bc),
        .issue_i       (iss),
        .advance_i     (adv),
        .verdict_o     (verdict),
        .slot_cnt_o    (cnt)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle();
        vld = 0; cls = 0; fo = 0; sg = 0; cr = 0; sc = 0; bc = 0; iss = 0; adv = 0;
    endtask

    // Drive at falling edge, read verdict 2 ns later, count after next rising edge (R11).
    task automatic step(input vec_t v);
        @(negedge clk);
        rst = v.rst; vld = v.vld; cls = v.cls; fo = v.fo; sg = v.sg;
        cr = v.cr; sc = v.sc; bc = v.bc; iss = v.iss; adv = v.adv;
        #2;
        check($sformatf("R%0d", v.req), "verdict", int'(verdict), int'(v.ev));
        @(negedge clk);
        check($sformatf("R%0d", v.req), "count", int'(cnt), int'(v.ec));
        idle();
        rst = 0;
    endtask

    initial begin
        #1_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        vld = 1; cls = 3'd1;
        #2;
        check("R1", "reset count", int'(cnt), 0);
        check("R1", "reset verdict", int'(verdict), 0);
        idle();

        for (int i = 0; i < NV; i++) begin
            step(VECS[i]);
        end

        // Directed: single at empty group is ok (R2), vector permute cracked fills (R3).
        step('{1'b0,1'b1,3'd5,1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'd0,3'd0,4'd2});  // R2
        step('{1'b0,1'b1,3'd5,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,3'd2,4'd3});  // R3
        step('{1'b0,1'b1,3'd5,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd0,3'd4,4'd3});  // R3
        step('{1'b0,1'b1,3'd5,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'd1,3'd4,4'd4});  // R4
        // Cracked branch at 4 closes the group (R8).
        step('{1'b0,1'b1,3'd7,1'b0,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,2'd1,3'd0,4'd8});  // R8
        // Pseudo with indirect branch after ctr write gets ok (R10).
        step('{1'b0,1'b1,3'd1,1'b0,1'b0,1'b0,1'b1,1'b0,1'b1,1'b0,2'd0,3'd1,4'd6});  // R6
        step('{1'b0,1'b1,3'd0,1'b0,1'b0,1'b0,1'b0,1'b1,1'b0,1'b0,2'd0,3'd1,4'd10}); // R10
        // Invalid candidate never hazards (R11 combinational path).
        step('{1'b0,1'b0,3'd6,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,2'd0,3'd1,4'd11}); // R11

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule